// File: doc/BRIEF.md
# Accumulator CPU fetch-execute sequencer

This block is a small accumulator processor core. A state machine moves every instruction through explicit register transfers. The program counter goes to the memory address register. One wait state follows while memory answers, and the returned word lands in the memory data register. It is then copied into the current instruction register and decoded into an opcode, an addressing-mode flag and an operand. A direct operand goes back out through the address register to fetch data. An immediate operand is placed straight into the data register. Execution then updates the accumulator, writes memory, redirects the program counter or stops the machine.

A single memory port serves both instructions and data. The port has a registered address output, a read data input with one cycle of latency, a write data output and a one-cycle write strobe. The accumulator, program counter and a halted flag are brought out so that the surrounding logic can see the result of a program. The core advances exactly one state on every rising clock edge.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears the accumulator, program counter and all internal registers and enters the fetch state. While reset is held and just after it, acc_o, pc_o, mem_addr and mem_we read 0 and halted_o reads 0. Reset also releases a halted core.
- R2: Instruction fetch copies the program counter into the address register, waits one cycle, loads the data register, increments the program counter, copies the data register to the instruction register and decodes it. Fetch plus decode takes 5 clock cycles. During the wait cycle mem_addr equals the program counter. The word format is opcode in [15:12], reserved bits in [11:9], mode in [8] (1 = immediate, 0 = direct) and operand in [7:0]. Data reads use bits [7:0]. Opcodes: 0 NOP, 1 LDA, 2 STA, 3 ADD, 4 SUB, 5 JMP, F HLT.
- R3: With mode 1, LDA, ADD and SUB use the operand itself as data. Each of these instructions takes 6 cycles in total.
- R4: With mode 0, LDA, ADD and SUB read their data from memory at the operand address, which needs one wait state. Each of these instructions takes 8 cycles in total.
- R5: LDA replaces the accumulator with its data value.
- R6: ADD and SUB add the data value to, or subtract it from, the accumulator modulo 256.
- R7: STA writes the accumulator to memory at the operand address, whatever the mode bit says. It raises mem_we for exactly one cycle and takes 6 cycles in total.
- R8: JMP loads the program counter from the operand, whatever the mode bit says, and takes 5 cycles. Fetch then continues from the new address.
- R9: Opcode 0, any undefined opcode, and any word whose reserved bits [11:9] are not all zero execute as NOP. Such a word leaves the accumulator unchanged and takes 5 cycles.
- R10: HLT stops the core one cycle after decode. From then on halted_o stays at 1, and the program counter and accumulator hold their values. No memory write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address, driven from the address register |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_wdata | output | 8 | Memory write data (accumulator) |
| mem_we | output | 1 | One-cycle memory write strobe |
| acc_o | output | 8 | Accumulator value |
| pc_o | output | 8 | Program counter value |
| halted_o | output | 1 | High once a HLT instruction has executed |

## Verification
The core has no status output beyond halted_o, so a wrong internal state shows up in two ways. A missed or extra transfer changes the number of cycles before halted_o rises. A corrupted register changes the final accumulator, program counter or memory contents. Each program is therefore checked for its exact cycle count to halt as well as its final values. A wrong fetch address becomes visible on mem_addr within one cycle of the wait state. A stray or stretched write strobe is counted at the memory model and changes memory before the next instruction.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [3:0] {
      OP_NOP = 4'h0,
      OP_LDA = 4'h1,
      OP_STA = 4'h2,
      OP_ADD = 4'h3,
      OP_SUB = 4'h4,
      OP_JMP = 4'h5,
      OP_HLT = 4'hF
   } opcode_e;

   typedef enum logic [3:0] {
      S_FADDR, S_FWAIT, S_FLOAD, S_FCIR, S_DECODE,
      S_DWAIT, S_DLOAD, S_EXEC, S_STORE, S_HALT
   } state_e;

   typedef enum logic [1:0] { ALU_PASS, ALU_ADD, ALU_SUB } alu_op_e;

   typedef enum logic [2:0] { K_NOP, K_ALU, K_STORE, K_JUMP, K_HALT } kind_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_core_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int RSV_W  = 3,
   localparam int INSN_W = OPC_W + RSV_W + 1 + WORD_W
) (
   input  logic [INSN_W-1:0] insn,
   output kind_e             kind,
   output alu_op_e           alu_op,
   output logic              imm,
   output logic [WORD_W-1:0] operand
);

   localparam int MODE_BIT = WORD_W;
   localparam int RSV_LSB  = WORD_W + 1;

   logic [OPC_W-1:0] opc;
   logic [RSV_W-1:0] rsvd;

   always_comb begin
      opc     = insn[INSN_W-1 -: OPC_W];
      rsvd    = insn[RSV_LSB +: RSV_W];
      imm     = insn[MODE_BIT];
      operand = insn[WORD_W-1:0];
      kind    = K_NOP;
      alu_op  = ALU_PASS;
      if (rsvd == '0) begin
         case (opc)
            OP_LDA:  begin kind = K_ALU; alu_op = ALU_PASS; end
            OP_ADD:  begin kind = K_ALU; alu_op = ALU_ADD;  end
            OP_SUB:  begin kind = K_ALU; alu_op = ALU_SUB;  end
            OP_STA:  kind = K_STORE;
            OP_JMP:  kind = K_JUMP;
            OP_HLT:  kind = K_HALT;
            default: kind = K_NOP;
         endcase
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int WORD_W            = 8,
   parameter bit SUB_BY_COMPLEMENT = 1'b1
) (
   input  alu_op_e           op,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] y
);

   logic [WORD_W-1:0] diff;

   generate
      if (SUB_BY_COMPLEMENT) begin : g_sub_cpl
         always_comb diff = a + ~b + WORD_W'(1);
      end else begin : g_sub_dir
         always_comb diff = a - b;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_PASS: y = b;
         ALU_ADD:  y = a + b;
         ALU_SUB:  y = diff;
         default:  y = a;
      endcase
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int WORD_W            = 8,
   parameter int RSV_W             = 3,
   parameter bit SUB_BY_COMPLEMENT = 1'b1,
   localparam int INSN_W = OPC_W + RSV_W + 1 + WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [WORD_W-1:0] mem_addr,
   input  logic [INSN_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [WORD_W-1:0] acc_o,
   output logic [WORD_W-1:0] pc_o,
   output logic              halted_o
);

   generate
      if (WORD_W < 2 || WORD_W > 16) begin : g_bad_word
         $error("acc_core: WORD_W must be 2..16");
      end
      if (RSV_W < 1) begin : g_bad_rsv
         $error("acc_core: RSV_W must be at least 1");
      end
   endgenerate

   state_e            state;
   logic [WORD_W-1:0] pc, mar, acc;
   logic [INSN_W-1:0] mdr, cir;

   kind_e             kind;
   alu_op_e           alu_op;
   logic              imm;
   logic [WORD_W-1:0] operand;
   logic [WORD_W-1:0] alu_y;

   acc_decode #(.WORD_W(WORD_W), .RSV_W(RSV_W)) u_dec (
      .insn(cir), .kind(kind), .alu_op(alu_op), .imm(imm), .operand(operand)
   );

   acc_alu #(.WORD_W(WORD_W), .SUB_BY_COMPLEMENT(SUB_BY_COMPLEMENT)) u_alu (
      .op(alu_op), .a(acc), .b(mdr[WORD_W-1:0]), .y(alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_FADDR;
         pc    <= '0;
         mar   <= '0;
         mdr   <= '0;
         cir   <= '0;
         acc   <= '0;
      end else begin
         case (state)
            S_FADDR: begin
               mar   <= pc;
               state <= S_FWAIT;
            end
            S_FWAIT: state <= S_FLOAD;
            S_FLOAD: begin
               mdr   <= mem_rdata;
               pc    <= pc + WORD_W'(1);
               state <= S_FCIR;
            end
            S_FCIR: begin
               cir   <= mdr;
               state <= S_DECODE;
            end
            S_DECODE: begin
               case (kind)
                  K_HALT:  state <= S_HALT;
                  K_JUMP: begin
                     pc    <= operand;
                     state <= S_FADDR;
                  end
                  K_STORE: begin
                     mar   <= operand;
                     state <= S_STORE;
                  end
                  K_ALU: begin
                     if (imm) begin
                        mdr   <= INSN_W'(operand);
                        state <= S_EXEC;
                     end else begin
                        mar   <= operand;
                        state <= S_DWAIT;
                     end
                  end
                  default: state <= S_FADDR;
               endcase
            end
            S_DWAIT: state <= S_DLOAD;
            S_DLOAD: begin
               mdr   <= mem_rdata;
               state <= S_EXEC;
            end
            S_EXEC: begin
               acc   <= alu_y;
               state <= S_FADDR;
            end
            S_STORE: state <= S_FADDR;
            S_HALT:  state <= S_HALT;
            default: state <= S_FADDR;
         endcase
      end
   end

   always_comb begin
      mem_addr  = mar;
      mem_wdata = acc;
      mem_we    = (state == S_STORE);
      acc_o     = acc;
      pc_o      = pc;
      halted_o  = (state == S_HALT);
   end

   AST_FETCH_ADDR_PC: assert property (@(posedge clk) disable iff (rst)
      (state == S_FWAIT) |-> (mem_addr == pc)); // R2

   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (state == S_FLOAD) |=> (pc == $past(pc) + WORD_W'(1))); // R2

   AST_ACC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
      (state != S_EXEC) |=> $stable(acc)); // R9

   AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we); // R7

   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      halted_o |=> (halted_o && $stable(pc) && !mem_we)); // R10

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
   import acc_core_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  mem_addr, mem_wdata, acc_o, pc_o;
   logic [15:0] mem_rdata;
   logic        mem_we, halted_o;

   always #5 clk = ~clk;

   acc_core uut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .acc_o(acc_o), .pc_o(pc_o),
      .halted_o(halted_o)
   );

   logic [15:0] mem [256];
   int checks = 0;
   int errors = 0;
   int we_cnt = 0;

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= {8'h00, mem_wdata};
         we_cnt <= we_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
   end

   // {opcode, mode, operand, starting acc, expected acc}
   localparam logic [28:0] VEC [9] = '{
      {4'h1, 1'b1, 8'h3C, 8'h00, 8'h3C},
      {4'h1, 1'b0, 8'h42, 8'h00, 8'h18},
      {4'h3, 1'b1, 8'h07, 8'h10, 8'h17},
      {4'h3, 1'b0, 8'h80, 8'h01, 8'hDB},
      {4'h3, 1'b1, 8'h20, 8'hF0, 8'h10},
      {4'h4, 1'b1, 8'h10, 8'h05, 8'hF5},
      {4'h4, 1'b0, 8'h55, 8'h20, 8'h11},
      {4'h0, 1'b1, 8'h99, 8'h44, 8'h44},
      {4'h7, 1'b0, 8'h60, 8'h2B, 8'h2B}
   };

   function automatic logic [15:0] enc(logic [3:0] op, logic md, logic [7:0] opd);
      return {op, 3'b000, md, opd};
   endfunction

   function automatic logic [7:0] dat(int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++)
         mem[i] = (i < 16) ? 16'hF000 : {8'h00, dat(i)};
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      we_cnt = 0;
   endtask

   task automatic run(output int cyc);
      cyc = 0;
      while (!halted_o && cyc < 400) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL R10 watchdog: actual no halt expected halt");
      report();
   end

   initial begin
      int cyc;
      logic [3:0] op;
      logic       md;
      logic [7:0] opd, seed, exp;
      int         xc;
      string      tag, ctag;

      // Reset state, R1
      clear_mem();
      mem[0] = enc(OP_LDA, 1'b1, 8'h01);
      mem[1] = enc(OP_HLT, 1'b0, 8'h00);
      @(negedge clk);
      do_reset();
      check("R1", acc_o, 0, "acc after reset");
      check("R1", pc_o, 0, "pc after reset");
      check("R1", halted_o, 0, "halted after reset");
      check("R1", mem_we, 0, "we after reset");
      check("R1", mem_addr, 0, "addr after reset");

      // Fetch sequencing, R2
      @(posedge clk); @(negedge clk);
      check("R2", mem_addr, 0, "fetch address in wait cycle");
      check("R2", pc_o, 0, "pc before increment");
      repeat (2) begin @(posedge clk); @(negedge clk); end
      check("R2", pc_o, 1, "pc after data register load");
      repeat (4) begin @(posedge clk); @(negedge clk); end
      check("R2", mem_addr, 1, "second fetch address");
      run(cyc);
      check("R2", cyc, 4, "remaining cycles to halt");
      check("R5", acc_o, 8'h01, "immediate load");

      // Vector table
      for (int v = 0; v < 9; v++) begin
         {op, md, opd, seed, exp} = VEC[v];
         clear_mem();
         mem[0] = enc(OP_LDA, 1'b1, seed);
         mem[1] = enc(op, md, opd);
         mem[2] = enc(OP_HLT, 1'b0, 8'h00);
         do_reset();
         run(cyc);
         if (op == 4'h1) tag = "R5";
         else if (op == 4'h3 || op == 4'h4) tag = "R6";
         else tag = "R9";
         if (op == 4'h1 || op == 4'h3 || op == 4'h4) begin
            xc   = md ? 6 : 8;
            ctag = md ? "R3" : "R4";
         end else begin
            xc   = 5;
            ctag = "R9";
         end
         check(tag, acc_o, exp, $sformatf("vector %0d acc", v));
         check(ctag, cyc, 11 + xc, $sformatf("vector %0d cycles", v));
         check("R2", pc_o, 3, $sformatf("vector %0d pc", v));
      end

      // Store, R7: both modes address memory
      clear_mem();
      mem[0] = enc(OP_LDA, 1'b1, 8'h9C);
      mem[1] = enc(OP_STA, 1'b0, 8'h70);
      mem[2] = enc(OP_STA, 1'b1, 8'h71);
      mem[3] = enc(OP_HLT, 1'b0, 8'h00);
      do_reset();
      run(cyc);
      check("R7", mem[8'h70], 16'h009C, "direct store");
      check("R7", mem[8'h71], 16'h009C, "store with mode bit set");
      check("R7", we_cnt, 2, "write strobe cycles");
      check("R7", cyc, 23, "store program cycles");

      // Halt freeze, R10
      repeat (20) @(posedge clk);
      @(negedge clk);
      check("R10", halted_o, 1, "halted held");
      check("R10", pc_o, 4, "pc held after halt");
      check("R10", acc_o, 8'h9C, "acc held after halt");
      check("R10", we_cnt, 2, "no writes while halted");

      // Reset releases halt, R1
      do_reset();
      check("R1", halted_o, 0, "reset leaves halt");
      check("R1", acc_o, 0, "reset clears acc");
      check("R1", pc_o, 0, "reset clears pc");

      // Jumps, R8
      clear_mem();
      mem[8'h00] = enc(OP_JMP, 1'b1, 8'h20);
      mem[8'h01] = enc(OP_LDA, 1'b1, 8'h11);
      mem[8'h20] = enc(OP_LDA, 1'b1, 8'h33);
      mem[8'h21] = enc(OP_JMP, 1'b0, 8'h30);
      mem[8'h22] = enc(OP_LDA, 1'b1, 8'h44);
      mem[8'h30] = enc(OP_HLT, 1'b0, 8'h00);
      do_reset();
      run(cyc);
      check("R8", acc_o, 8'h33, "acc after jumps");
      check("R8", pc_o, 8'h31, "pc after jumps");
      check("R8", cyc, 21, "jump program cycles");

      // Reserved bits set, R9
      clear_mem();
      mem[0] = enc(OP_LDA, 1'b1, 8'h21);
      mem[1] = {4'h3, 3'b010, 1'b1, 8'h05};
      mem[2] = enc(OP_HLT, 1'b0, 8'h00);
      do_reset();
      run(cyc);
      check("R9", acc_o, 8'h21, "reserved bits make NOP");
      check("R9", cyc, 16, "reserved-bit word cycles");

      report();
   end

endmodule